// File: doc/BRIEF.md
# Serial Flash Status Register File

This block keeps the three 8-bit status and configuration registers of a serial flash device. It also executes the commands that touch them. An SPI slave front end delivers each chip-select frame as a stream of events: a frame-start pulse, one valid pulse per received byte, and a frame-end pulse. The first byte of a frame is the opcode. The bytes that follow are data.

For a register read, the block returns a byte that the front end shifts out. The front end may repeat that byte for as long as it keeps clocking. The rest of the device sees the register contents continuously. It supplies the live busy and suspend flags that appear in the registers.

A write-status command can update the first register only, the first two, or all three, in that fixed order, inside one frame. It is committed only when the frame closes. Read-only bits are never touched by a write. The one-time-programmable lock bits can only be set, never cleared. The block can also grant write permission for the volatile register copies, as an alternative to the write-enable latch.

Top module: `flash_status_regs`

## Requirements
- R1: After reset the three register views read as follows. `sr1_o` is 00h with its bit 0 following `busy_i`. `sr2_o` is 00h with its bit 7 following `sus_i`. `sr3_o` is 70h, that is wrap length 11b in bits 6:5, wrap disabled in bit 4, latency 0 in bits 3:0. `rd_vld_o` is 0.
- R2: A frame whose opcode is 06h sets the write-enable latch (bit 1 of `sr1_o`). A frame with opcode 04h clears it. The change is visible in the cycle after frame end.
- R3: Opcodes 05h, 35h and 33h select register 1, 2 and 3 for reading. From the cycle after the opcode byte until frame end, `rd_vld_o` is 1 and `rd_data_o` shows the live register value, with register 1 bit 0 = `busy_i` and register 2 bit 7 = `sus_i`. The byte stays valid for as long as the frame lasts. `rd_vld_o` is 0 in the cycle after frame end.
- R4: Opcode 01h takes its data bytes in the order register 1, register 2, register 3. It applies as many bytes as arrived, at most three, and drops any further bytes. A permitted write with no data bytes changes no register. A write permitted by the write-enable latch clears that latch.
- R5: A 01h frame that arrives with neither the write-enable latch nor the volatile permission set changes nothing.
- R6: Write data never changes read-only positions. These are register 1 bits 1:0, register 2 bit 7 and register 3 bit 7. Register 3 bit 7 always reads 0.
- R7: Register 2 bits 5:2 are lock bits. A write can set them to 1 but can never return them to 0.
- R8: If `busy_i` is 1 at the frame end of a 01h frame, the write is ignored and the write-enable latch is kept. Reads still work while busy.
- R9: Stored register bits change only in the cycle after a frame-end pulse.
- R10: Opcode 50h grants permission for exactly the next frame. A 01h write in that frame commits without the latch and leaves the latch unchanged. The permission is consumed by whatever frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_start_i | input | 1 | Chip-select frame begins (pulse) |
| byte_vld_i | input | 1 | Received byte valid (pulse) |
| byte_i | input | 8 | Received byte |
| frm_end_i | input | 1 | Chip-select frame ends (pulse) |
| busy_i | input | 1 | Embedded operation in progress |
| sus_i | input | 1 | Program/erase suspended |
| rd_vld_o | output | 1 | Read byte valid for shifting out |
| rd_data_o | output | 8 | Read byte |
| sr1_o | output | 8 | Register 1 view |
| sr2_o | output | 8 | Register 2 view |
| sr3_o | output | 8 | Register 3 view |

## Verification
The write command is swept through every value for each register. The sweeps use one, two and three data bytes, so the per-register write masks, the read-only positions and the fixed write order are each isolated. The register 2 sweep runs in ascending order, so any lock bit that drops back to 0 after an earlier value set it shows up at once. Directed frames separate the permission paths: no permission, the latch, the one-shot volatile grant, the grant combined with the latch, a busy frame end, zero data bytes, and a surplus fourth byte. Reads are taken while the busy and suspend inputs move, to show that the live bits pass through.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 3;
  localparam int CNT_W    = $clog2(NUM_REGS + 1);

  localparam logic [REG_W-1:0] OP_WRSR  = 8'h01;
  localparam logic [REG_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [REG_W-1:0] OP_RD1   = 8'h05;
  localparam logic [REG_W-1:0] OP_WREN  = 8'h06;
  localparam logic [REG_W-1:0] OP_RD3   = 8'h33;
  localparam logic [REG_W-1:0] OP_RD2   = 8'h35;
  localparam logic [REG_W-1:0] OP_VWREN = 8'h50;

  // index 0 = register 1
  localparam logic [NUM_REGS-1:0][REG_W-1:0] WR_MASK  = {8'h7F, 8'h7F, 8'hFC};
  localparam logic [NUM_REGS-1:0][REG_W-1:0] OTP_MASK = {8'h00, 8'h3C, 8'h00};
  localparam logic [NUM_REGS-1:0][REG_W-1:0] RST_VAL  = {8'h70, 8'h00, 8'h00};

  localparam int WEL_BIT  = 1;
  localparam int BUSY_BIT = 0;
  localparam int SUS_BIT  = 7;
endpackage

// File: rtl/sfr_frame_dec.sv
module sfr_frame_dec
  import sfr_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               frm_start_i,
  input  logic                               byte_vld_i,
  input  logic [REG_W-1:0]                   byte_i,
  input  logic                               frm_end_i,
  output logic                               in_frame_o,
  output logic                               have_op_o,
  output logic [REG_W-1:0]                   op_o,
  output logic [CNT_W-1:0]                   cnt_o,
  output logic [NUM_REGS-1:0][REG_W-1:0]     stage_o
);
  logic take_byte;
  assign take_byte = byte_vld_i && in_frame_o && !frm_start_i && !frm_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_o <= 1'b0;
      have_op_o  <= 1'b0;
      op_o       <= '0;
      cnt_o      <= '0;
    end else if (frm_start_i) begin
      in_frame_o <= 1'b1;
      have_op_o  <= 1'b0;
      cnt_o      <= '0;
    end else if (frm_end_i) begin
      in_frame_o <= 1'b0;
      have_op_o  <= 1'b0;
    end else if (take_byte) begin
      if (!have_op_o) begin
        op_o      <= byte_i;
        have_op_o <= 1'b1;
      end else if (cnt_o < CNT_W'(NUM_REGS)) begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        stage_o[g] <= '0;
      else if (take_byte && have_op_o && cnt_o == CNT_W'(g))
        stage_o[g] <= byte_i;
    end
  end
endmodule

// File: rtl/sfr_reg_core.sv
module sfr_reg_core
  import sfr_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           end_i,
  input  logic [REG_W-1:0]               op_i,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic [NUM_REGS-1:0][REG_W-1:0] stage_i,
  input  logic                           busy_i,
  output logic [NUM_REGS-1:0][REG_W-1:0] reg_o,
  output logic                           wel_o
);
  logic vwe_q;
  logic wr_ok;

  assign wr_ok = end_i && (op_i == OP_WRSR) && !busy_i && (wel_o || vwe_q);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] nxt;
    assign nxt = (reg_o[g] & ~WR_MASK[g])
               | (stage_i[g] & WR_MASK[g] & ~OTP_MASK[g])
               | ((reg_o[g] | stage_i[g]) & OTP_MASK[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reg_o[g] <= RST_VAL[g] & WR_MASK[g];
      else if (wr_ok && cnt_i > CNT_W'(g))
        reg_o[g] <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o <= 1'b0;
      vwe_q <= 1'b0;
    end else if (end_i) begin
      vwe_q <= (op_i == OP_VWREN);
      if (op_i == OP_WREN)
        wel_o <= 1'b1;
      else if (op_i == OP_WRDI)
        wel_o <= 1'b0;
      else if (wr_ok && !vwe_q)
        wel_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sfr_rd_mux.sv
module sfr_rd_mux
  import sfr_pkg::*;
(
  input  logic             in_frame_i,
  input  logic             have_op_i,
  input  logic [REG_W-1:0] op_i,
  input  logic [REG_W-1:0] sr1_i,
  input  logic [REG_W-1:0] sr2_i,
  input  logic [REG_W-1:0] sr3_i,
  output logic             rd_vld_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic is_rd;
  always_comb begin
    is_rd     = 1'b1;
    rd_data_o = '0;
    unique case (op_i)
      OP_RD1:  rd_data_o = sr1_i;
      OP_RD2:  rd_data_o = sr2_i;
      OP_RD3:  rd_data_o = sr3_i;
      default: is_rd = 1'b0;
    endcase
  end
  assign rd_vld_o = in_frame_i && have_op_i && is_rd;
endmodule

// File: rtl/flash_status_regs.sv
module flash_status_regs
  import sfr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_start_i,
  input  logic             byte_vld_i,
  input  logic [REG_W-1:0] byte_i,
  input  logic             frm_end_i,
  input  logic             busy_i,
  input  logic             sus_i,
  output logic             rd_vld_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic [REG_W-1:0] sr1_o,
  output logic [REG_W-1:0] sr2_o,
  output logic [REG_W-1:0] sr3_o
);
  logic                           in_frame;
  logic                           have_op;
  logic [REG_W-1:0]               op;
  logic [CNT_W-1:0]               cnt;
  logic [NUM_REGS-1:0][REG_W-1:0] stage;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  logic                           wel;

  sfr_frame_dec u_dec (
    .clk_i, .rst_ni, .frm_start_i, .byte_vld_i, .byte_i, .frm_end_i,
    .in_frame_o(in_frame), .have_op_o(have_op), .op_o(op),
    .cnt_o(cnt), .stage_o(stage)
  );

  sfr_reg_core u_core (
    .clk_i, .rst_ni,
    .end_i(frm_end_i && have_op && !frm_start_i),
    .op_i(op), .cnt_i(cnt), .stage_i(stage), .busy_i,
    .reg_o(regs), .wel_o(wel)
  );

  always_comb begin
    sr1_o           = regs[0];
    sr1_o[WEL_BIT]  = wel;
    sr1_o[BUSY_BIT] = busy_i;
    sr2_o           = regs[1];
    sr2_o[SUS_BIT]  = sus_i;
    sr3_o           = regs[2];
  end

  sfr_rd_mux u_rd (
    .in_frame_i(in_frame), .have_op_i(have_op), .op_i(op),
    .sr1_i(sr1_o), .sr2_i(sr2_o), .sr3_i(sr3_o),
    .rd_vld_o, .rd_data_o
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frm_end_i,
  input logic       busy_i,
  input logic       rd_vld_o,
  input logic [7:0] sr1_o,
  input logic [7:0] sr2_o,
  input logic [7:0] sr3_o
);
  p_hold_between_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_end_i |=> ($stable(sr1_o[7:1]) && $stable(sr2_o[6:0]) && $stable(sr3_o)));

  p_busy_blocks_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_end_i && busy_i) |=> ($stable(sr1_o[7:2]) && $stable(sr2_o[6:0]) && $stable(sr3_o)));

  p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sr2_o[5:2] & $past(sr2_o[5:2])) == $past(sr2_o[5:2])));

  p_read_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_end_i |=> !rd_vld_o);

  p_rsvd_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr3_o[7] == 1'b0);
endmodule

bind flash_status_regs sfr_checker u_chk (.*);

// File: tb/sim_flash_status_regs.sv
module sim_flash_status_regs;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frm_start_i = 1'b0, byte_vld_i = 1'b0, frm_end_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       busy_i = 1'b0, sus_i = 1'b0;
  logic       rd_vld_o;
  logic [7:0] rd_data_o, sr1_o, sr2_o, sr3_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m1 = 8'h00, m2 = 8'h00, m3 = 8'h70;
  logic       mwel = 1'b0;

  always #5 clk = ~clk;

  flash_status_regs u0 (
    .clk_i(clk), .rst_ni, .frm_start_i, .byte_vld_i, .byte_i, .frm_end_i,
    .busy_i, .sus_i, .rd_vld_o, .rd_data_o, .sr1_o, .sr2_o, .sr3_o
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e1();
    return (m1 & 8'hFC) | {6'b0, mwel, busy_i};
  endfunction
  function automatic logic [7:0] e2();
    return (m2 & 8'h7F) | {sus_i, 7'b0};
  endfunction

  task automatic chk_all(string req);
    chk({req, " sr1"}, sr1_o, e1());
    chk({req, " sr2"}, sr2_o, e2());
    chk({req, " sr3"}, sr3_o, m3);
  endtask

  task automatic begin_frame();
    @(negedge clk) frm_start_i = 1'b1;
    @(negedge clk) frm_start_i = 1'b0;
  endtask
  task automatic send_byte(logic [7:0] b);
    @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
    @(negedge clk) byte_vld_i = 1'b0;
  endtask
  task automatic end_frame();
    @(negedge clk) frm_end_i = 1'b1;
    @(negedge clk) frm_end_i = 1'b0;
  endtask
  task automatic cmd(logic [7:0] op);
    begin_frame(); send_byte(op); end_frame();
  endtask

  // n data bytes (0..4); model applied only if permitted
  task automatic wrsr(int n, logic [7:0] b0, b1, b2, b3, bit permit, bit via_wel);
    begin_frame(); send_byte(8'h01);
    if (n > 0) send_byte(b0);
    if (n > 1) send_byte(b1);
    if (n > 2) send_byte(b2);
    if (n > 3) send_byte(b3);
    end_frame();
    if (permit) begin
      if (n > 0) m1 = b0 & 8'hFC;
      if (n > 1) m2 = (b1 & 8'h43) | ((m2 | b1) & 8'h3C);
      if (n > 2) m3 = b2 & 8'h7F;
      if (via_wel) mwel = 1'b0;
    end
  endtask

  task automatic read_chk(string req, logic [7:0] op, int sel);
    begin_frame(); send_byte(op);
    chk({req, " rd_vld"}, {7'b0, rd_vld_o}, 8'h01);
    chk({req, " rd_data"}, rd_data_o, sel == 1 ? e1() : sel == 2 ? e2() : m3);
    @(negedge clk); @(negedge clk);
    chk({req, " rd_repeat"}, rd_data_o, sel == 1 ? e1() : sel == 2 ? e2() : m3);
    end_frame();
    chk({req, " rd_vld_drop"}, {7'b0, rd_vld_o}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_all("R1");
    chk("R1 rd_vld", {7'b0, rd_vld_o}, 8'h00);

    // R2 latch set / clear
    cmd(8'h06); mwel = 1'b1; chk("R2 set", sr1_o, e1());
    cmd(8'h04); mwel = 1'b0; chk("R2 clear", sr1_o, e1());

    // R5 no permission
    wrsr(3, 8'hFF, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0);
    chk_all("R5");

    // R3 reads with live bits
    busy_i = 1'b1; sus_i = 1'b1;
    read_chk("R3 r1", 8'h05, 1);
    read_chk("R3 r2", 8'h35, 2);
    read_chk("R3 r3", 8'h33, 3);
    busy_i = 1'b0; sus_i = 1'b0;

    // R4 R6 sweep register 1
    for (int v = 0; v < 256; v++) begin
      cmd(8'h06); mwel = 1'b1;
      wrsr(1, v[7:0], 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
      chk_all("R4 R6 sr1 sweep");
    end

    // R7 sweep register 2 ascending
    for (int v = 0; v < 256; v++) begin
      cmd(8'h06); mwel = 1'b1;
      wrsr(2, 8'h00, v[7:0], 8'h00, 8'h00, 1'b1, 1'b1);
      chk("R7 R6 sr2 sweep", sr2_o, e2());
    end

    // R4 R6 sweep register 3 with readback
    for (int v = 0; v < 256; v++) begin
      cmd(8'h06); mwel = 1'b1;
      wrsr(3, 8'h5C, m2, v[7:0], 8'h00, 1'b1, 1'b1);
      chk_all("R4 sr3 sweep");
      if (v % 8 == 0) read_chk("R3 sr3 sweep", 8'h33, 3);
    end

    // R4 surplus byte dropped
    cmd(8'h06); mwel = 1'b1;
    wrsr(4, 8'h90, 8'h41, 8'h25, 8'hFF, 1'b1, 1'b1);
    chk_all("R4 fourth byte");

    // R4 zero data bytes: nothing changes, latch clears
    cmd(8'h06); mwel = 1'b1;
    wrsr(0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    chk_all("R4 zero bytes");

    // R8 busy at frame end
    cmd(8'h06); mwel = 1'b1;
    busy_i = 1'b1;
    wrsr(3, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    chk_all("R8 busy ignore");
    read_chk("R8 read busy", 8'h05, 1);
    busy_i = 1'b0;
    wrsr(1, 8'h08, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    chk_all("R8 after busy");

    // R10 volatile grant without latch
    cmd(8'h50);
    wrsr(1, 8'hA4, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    chk_all("R10 vwe write");
    wrsr(1, 8'h18, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    chk_all("R10 grant consumed");
    // grant consumed by an unrelated frame
    cmd(8'h50); cmd(8'h05);
    wrsr(1, 8'h18, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    chk_all("R10 grant lost");
    // grant with latch set keeps latch
    cmd(8'h06); mwel = 1'b1; cmd(8'h50);
    wrsr(1, 8'h64, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    chk_all("R10 latch kept");
    // R9 quiet cycles hold
    repeat (5) @(negedge clk);
    chk_all("R9 hold");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule